// File: doc/BRIEF.md
# Hierarchical Physical Address Decoder

This block takes a 51-bit physical address and sorts it into the domains a router needs. It reports the package index, the die index, the target class, the processing-element index and the sub-unit index, and the byte offset inside the target. The possible targets are HBM memory, a PE-local resource, a management-CPU resource, cube SRAM, an IO-CPU resource, and the UAL window on an IO chiplet. The decode is nested. The die class picks the layout of the 42 die-local bits. On a memory die, the resource class then picks the sub-layout. Every level has its own must-be-zero bits.

The block also checks each address against the architecture. It reports non-zero must-be-zero bits, reserved die codes, reserved class or sub-unit codes, and offsets that fall inside a fixed power-of-two slot but past the implemented budget of that sub-unit. HBM offsets are also checked against a capacity limit that software writes at run time. The field decode itself never depends on that limit.

Addresses enter through a valid/ready port. Results leave one register stage later through a second valid/ready port. The capacity register has a one-cycle write strobe.

Top module: `paddr_classifier`

## Requirements
- R1: `outSip` is address bits [50:47] and `outDie` is address bits [46:42], for every address, including faulted ones.
- R2: A die index from 21 to 31 gives `outKind` 7 (none), `outOffset` equal to address bits [39:0], and fault 2 (reserved die). Die 0–15 is a memory die and die 16–20 is an IO chiplet.
- R3: On a memory die, local bits [41:38] must be zero, or fault 1 (must-be-zero) is raised. When local bit 37 is 1 the target is HBM: kind 0, offset taken from bits [36:0].
- R4: On a memory die with bit 37 = 0, bits [36:34] select the resource: 0 gives PE (kind 1), 1 gives management CPU (kind 2), 2 gives cube SRAM (kind 3). Codes 3–7 give kind 7, offset equal to bits [33:0], and fault 3 (reserved code).
- R5: For a PE resource, bit 33 must be zero. The PE index is bits [32:29], the sub-unit is bits [28:25] and the offset is bits [24:0]. Sub-units 0–6 have budgets of 8K, 8K, 256K, 16K, 16K, 192K and 2M bytes. Sub-units 7–15 raise fault 3.
- R6: For a management-CPU resource, bits [33:30] must be zero. The sub-unit is bits [29:25] and the offset is bits [24:0]. Sub-units 0–5 have budgets of 512K, 512K, 256K, 8K, 16K and 10M bytes. Sub-units 6–31 raise fault 3.
- R7: For cube SRAM, bits [33:25] must be zero and the offset is bits [24:0]. There is no budget check.
- R8: On an IO chiplet, local bits [41:40] must be zero. A 40-bit chiplet offset below 0x8000_0000 targets the IO CPU (kind 4). Its sub-unit is bits [30:27], its offset is bits [26:0], and its budgets are 512K, 512K, 2M, 8K, 16K and 64M for sub-units 0–5, with 6–15 reserved (fault 3). Any larger chiplet offset targets UAL (kind 5) with offset bits [39:0].
- R9: A sub-offset equal to or above its sub-unit budget raises fault 4 (over budget).
- R10: An HBM offset equal to or above the capacity register raises fault 5 (over capacity). The capacity register resets to 2^37. It is written from `capWrData` when `capWrEn` is high. Each address is checked against the value the register holds in the cycle the address is accepted.
- R11: When several faults apply, the lowest fault code wins (1, then 2, 3, 4, 5). Fault 0 means the address is valid. All decoded fields are still reported when there is a fault. `outPe` is 0 unless the kind is 1. `outUnit` is 0 for kinds 0, 3, 5 and 7.
- R12: `inReady` equals `!outValid || outReady`. A result appears on the outputs in the cycle after its address is accepted. While `outValid` is high and `outReady` is low, the result stays unchanged.
- R13: While reset is asserted and right after it, `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Address offered |
| inReady | output | 1 | Address can be taken this cycle |
| inAddr | input | 51 | Physical address |
| capWrEn | input | 1 | Write strobe for the HBM capacity register |
| capWrData | input | 38 | New HBM capacity in bytes |
| outValid | output | 1 | Result held on the outputs |
| outReady | input | 1 | Consumer takes the result |
| outSip | output | 4 | Package index |
| outDie | output | 5 | Die index |
| outKind | output | 3 | Target: 0 HBM, 1 PE, 2 mgmt CPU, 3 cube SRAM, 4 IO CPU, 5 UAL, 7 none |
| outPe | output | 4 | PE index (PE targets only) |
| outUnit | output | 5 | Sub-unit index |
| outOffset | output | 40 | Offset within the target |
| outFault | output | 3 | 0 ok, 1 must-be-zero, 2 reserved die, 3 reserved code, 4 over budget, 5 over capacity |

## Verification
Every decoded field and the fault code are due exactly one clock after the cycle in which `inValid` and `inReady` are both high. They then stay on the outputs until the cycle in which `outReady` is seen high. The driver samples `inReady` on the falling edge before the accepting rising edge. It pushes the expected result at that point, using the capacity value that is still in force, so a capacity write made in the same cycle counts only for later addresses. The monitor compares on each falling edge where a transfer will complete, and it checks that the outputs stay unchanged during stalled cycles.

// File: rtl/paddr_pkg.sv
package paddr_pkg;
  localparam int ADDR_W   = 51;
  localparam int LOCAL_W  = 42;
  localparam int OFF_W    = 40;
  localparam int CAP_W    = 38;
  localparam int SUB_W    = 27;
  localparam int MEM_DIE_LAST  = 15;
  localparam int IO_DIE_LAST   = 20;

  typedef enum logic [2:0] {
    K_HBM = 3'd0, K_PE = 3'd1, K_MCPU = 3'd2, K_CUBE = 3'd3,
    K_IOCPU = 3'd4, K_UAL = 3'd5, K_NONE = 3'd7
  } kind_e;

  typedef enum logic [2:0] {
    F_OK = 3'd0, F_MBZ = 3'd1, F_RES_DIE = 3'd2, F_RES_CODE = 3'd3,
    F_BUDGET = 3'd4, F_CAP = 3'd5
  } fault_e;

  typedef struct packed {
    logic [3:0]       sip;
    logic [4:0]       die;
    kind_e            kind;
    logic [3:0]       pe;
    logic [4:0]       unit;
    logic [OFF_W-1:0] offset;
    fault_e           fault;
  } result_t;

  typedef struct packed {
    logic load;
    logic capLoad;
  } strobes_t;
endpackage

// File: rtl/paddr_flow_ctrl.sv
module paddr_flow_ctrl
  import paddr_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     outReady,
  input  logic     capWrEn,
  output logic     inReady,
  output logic     outValid,
  output strobes_t strobes
);
  logic holdQ;

  assign inReady         = !holdQ || outReady;
  assign strobes.load    = inValid && inReady;
  assign strobes.capLoad = capWrEn;
  assign outValid        = holdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ <= 1'b0;
    end else if (strobes.load) begin
      holdQ <= 1'b1;
    end else if (outReady) begin
      holdQ <= 1'b0;
    end
  end
endmodule

// File: rtl/paddr_decode_path.sv
module paddr_decode_path
  import paddr_pkg::*;
#(
  parameter logic [CAP_W-1:0] CAP_RESET = 38'h20_0000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [CAP_W-1:0]  capWrData,
  output result_t           resultQ
);
  logic [CAP_W-1:0]   capQ;
  logic [LOCAL_W-1:0] loc;
  result_t            nxt;
  logic [SUB_W-1:0]   subOff;
  logic [SUB_W-1:0]   limit;
  logic               useBudget, mbzHit, resDie, resCode, overBud, overCap;

  function automatic logic [SUB_W-1:0] peLimit(input logic [3:0] u);
    case (u)
      4'd0, 4'd1: peLimit = 27'h000_2000;
      4'd2:       peLimit = 27'h004_0000;
      4'd3, 4'd4: peLimit = 27'h000_4000;
      4'd5:       peLimit = 27'h003_0000;
      4'd6:       peLimit = 27'h020_0000;
      default:    peLimit = '0;
    endcase
  endfunction

  function automatic logic [SUB_W-1:0] mcpuLimit(input logic [4:0] u);
    case (u)
      5'd0, 5'd1: mcpuLimit = 27'h008_0000;
      5'd2:       mcpuLimit = 27'h004_0000;
      5'd3:       mcpuLimit = 27'h000_2000;
      5'd4:       mcpuLimit = 27'h000_4000;
      5'd5:       mcpuLimit = 27'h0A0_0000;
      default:    mcpuLimit = '0;
    endcase
  endfunction

  function automatic logic [SUB_W-1:0] ioLimit(input logic [3:0] u);
    case (u)
      4'd0, 4'd1: ioLimit = 27'h008_0000;
      4'd2:       ioLimit = 27'h020_0000;
      4'd3:       ioLimit = 27'h000_2000;
      4'd4:       ioLimit = 27'h000_4000;
      4'd5:       ioLimit = 27'h400_0000;
      default:    ioLimit = '0;
    endcase
  endfunction

  assign loc = inAddr[LOCAL_W-1:0];

  always_comb begin
    nxt        = '0;
    nxt.sip    = inAddr[50:47];
    nxt.die    = inAddr[46:42];
    nxt.kind   = K_NONE;
    subOff     = '0;
    limit      = '0;
    useBudget  = 1'b0;
    mbzHit     = 1'b0;
    resDie     = 1'b0;
    resCode    = 1'b0;
    overBud    = 1'b0;
    overCap    = 1'b0;

    if (nxt.die <= 5'(MEM_DIE_LAST)) begin
      mbzHit = (loc[41:38] != '0);
      if (loc[37]) begin
        nxt.kind   = K_HBM;
        nxt.offset = OFF_W'(loc[36:0]);
        overCap    = ({1'b0, loc[36:0]} >= capQ);
      end else begin
        case (loc[36:34])
          3'd0: begin
            nxt.kind   = K_PE;
            mbzHit     = mbzHit || loc[33];
            nxt.pe     = loc[32:29];
            nxt.unit   = {1'b0, loc[28:25]};
            nxt.offset = OFF_W'(loc[24:0]);
            subOff     = SUB_W'(loc[24:0]);
            limit      = peLimit(loc[28:25]);
            useBudget  = 1'b1;
          end
          3'd1: begin
            nxt.kind   = K_MCPU;
            mbzHit     = mbzHit || (loc[33:30] != '0);
            nxt.unit   = loc[29:25];
            nxt.offset = OFF_W'(loc[24:0]);
            subOff     = SUB_W'(loc[24:0]);
            limit      = mcpuLimit(loc[29:25]);
            useBudget  = 1'b1;
          end
          3'd2: begin
            nxt.kind   = K_CUBE;
            mbzHit     = mbzHit || (loc[33:25] != '0);
            nxt.offset = OFF_W'(loc[24:0]);
          end
          default: begin
            resCode    = 1'b1;
            nxt.offset = OFF_W'(loc[33:0]);
          end
        endcase
      end
    end else if (nxt.die <= 5'(IO_DIE_LAST)) begin
      mbzHit = (loc[41:40] != '0);
      if (loc[39:31] == '0) begin
        nxt.kind   = K_IOCPU;
        nxt.unit   = {1'b0, loc[30:27]};
        nxt.offset = OFF_W'(loc[26:0]);
        subOff     = loc[26:0];
        limit      = ioLimit(loc[30:27]);
        useBudget  = 1'b1;
      end else begin
        nxt.kind   = K_UAL;
        nxt.offset = loc[39:0];
      end
    end else begin
      resDie     = 1'b1;
      nxt.offset = loc[39:0];
    end

    if (useBudget) begin
      resCode = (limit == '0);
      overBud = (limit != '0) && (subOff >= limit);
    end

    if (mbzHit)       nxt.fault = F_MBZ;
    else if (resDie)  nxt.fault = F_RES_DIE;
    else if (resCode) nxt.fault = F_RES_CODE;
    else if (overBud) nxt.fault = F_BUDGET;
    else if (overCap) nxt.fault = F_CAP;
    else              nxt.fault = F_OK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capQ    <= CAP_RESET;
      resultQ <= '0;
    end else begin
      if (strobes.capLoad) capQ <= capWrData;
      if (strobes.load)    resultQ <= nxt;
    end
  end
endmodule

// File: rtl/paddr_classifier.sv
module paddr_classifier
  import paddr_pkg::*;
#(
  parameter logic [CAP_W-1:0] CAP_RESET = 38'h20_0000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              capWrEn,
  input  logic [CAP_W-1:0]  capWrData,
  output logic              outValid,
  input  logic              outReady,
  output logic [3:0]        outSip,
  output logic [4:0]        outDie,
  output logic [2:0]        outKind,
  output logic [3:0]        outPe,
  output logic [4:0]        outUnit,
  output logic [OFF_W-1:0]  outOffset,
  output logic [2:0]        outFault
);
  strobes_t strobes;
  result_t  res;

  paddr_flow_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .capWrEn(capWrEn), .inReady(inReady), .outValid(outValid), .strobes(strobes)
  );

  paddr_decode_path #(.CAP_RESET(CAP_RESET)) u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inAddr(inAddr),
    .capWrData(capWrData), .resultQ(res)
  );

  assign outSip    = res.sip;
  assign outDie    = res.die;
  assign outKind   = res.kind;
  assign outPe     = res.pe;
  assign outUnit   = res.unit;
  assign outOffset = res.offset;
  assign outFault  = res.fault;
endmodule

// File: rtl/paddr_classifier_chk.sv
module paddr_classifier_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic [4:0]  outDie,
  input logic [2:0]  outKind,
  input logic [3:0]  outPe,
  input logic [39:0] outOffset,
  input logic [2:0]  outFault
);
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outFault) && $stable(outOffset) && $stable(outKind));

  assert_ready_R12: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

  assert_load_R12: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid);

  assert_resdie_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outFault == 3'd2 |-> outDie >= 5'd21 && outKind == 3'd7);

  assert_memdie_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outDie <= 5'd20 |-> outFault != 3'd2);

  assert_caphbm_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outFault == 3'd5 |-> outKind == 3'd0);

  assert_peidx_R11: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outKind != 3'd1 |-> outPe == 4'd0);
endmodule

bind paddr_classifier paddr_classifier_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outDie(outDie), .outKind(outKind),
  .outPe(outPe), .outOffset(outOffset), .outFault(outFault)
);

// File: tb/paddr_classifier_bench.sv
module paddr_classifier_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [50:0] inAddr = '0;
  logic        capWrEn = 1'b0;
  logic [37:0] capWrData = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [3:0]  outSip;
  logic [4:0]  outDie;
  logic [2:0]  outKind;
  logic [3:0]  outPe;
  logic [4:0]  outUnit;
  logic [39:0] outOffset;
  logic [2:0]  outFault;

  int checks = 0;
  int errors = 0;
  logic [37:0] capModel = 38'h20_0000_0000;
  logic [63:0] expQ[$];
  string       tagQ[$];
  bit          bpOn = 1'b0;
  bit          doneFlag = 1'b0;

  always #10 clk = ~clk;

  paddr_classifier u_paddr_classifier (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inAddr(inAddr),
    .capWrEn(capWrEn), .capWrData(capWrData), .outValid(outValid), .outReady(outReady),
    .outSip(outSip), .outDie(outDie), .outKind(outKind), .outPe(outPe),
    .outUnit(outUnit), .outOffset(outOffset), .outFault(outFault)
  );

  function automatic longint budgetOf(int cls, int u);
    longint t[3][6] = '{
      '{64'h2000, 64'h2000, 64'h40000, 64'h4000, 64'h4000, 64'h30000},
      '{64'h80000, 64'h80000, 64'h40000, 64'h2000, 64'h4000, 64'hA00000},
      '{64'h80000, 64'h80000, 64'h200000, 64'h2000, 64'h4000, 64'h4000000}};
    if (cls == 0 && u == 6) return 64'h200000;
    if (u > 5) return 0;
    return t[cls][u];
  endfunction

  function automatic logic [63:0] model(logic [50:0] a, logic [37:0] cap);
    logic [41:0] l;
    int die, kind, pe, unit, f;
    logic [39:0] off;
    longint lim, sub;
    bit m, rd, rc, ob, oc, bud;
    l = a[41:0]; die = int'(a[46:42]);
    kind = 7; pe = 0; unit = 0; off = '0; lim = 0; sub = 0;
    m = 0; rd = 0; rc = 0; ob = 0; oc = 0; bud = 0;
    if (die > 20) begin
      rd = 1; off = l[39:0];
    end else if (die > 15) begin
      m = (l[41:40] != 0);
      if (l[39:0] < 40'h8000_0000) begin
        kind = 4; unit = int'(l[30:27]); off = 40'(l[26:0]);
        sub = longint'(l[26:0]); lim = budgetOf(2, unit); bud = 1;
      end else begin
        kind = 5; off = l[39:0];
      end
    end else begin
      m = (l[41:38] != 0);
      if (l[37]) begin
        kind = 0; off = 40'(l[36:0]); oc = ({1'b0, l[36:0]} >= cap);
      end else if (l[36:34] == 0) begin
        kind = 1; m = m || l[33]; pe = int'(l[32:29]); unit = int'(l[28:25]);
        off = 40'(l[24:0]); sub = longint'(l[24:0]); lim = budgetOf(0, unit); bud = 1;
      end else if (l[36:34] == 1) begin
        kind = 2; m = m || (l[33:30] != 0); unit = int'(l[29:25]);
        off = 40'(l[24:0]); sub = longint'(l[24:0]); lim = budgetOf(1, unit); bud = 1;
      end else if (l[36:34] == 2) begin
        kind = 3; m = m || (l[33:25] != 0); off = 40'(l[24:0]);
      end else begin
        rc = 1; off = 40'(l[33:0]);
      end
    end
    if (bud) begin
      rc = (lim == 0);
      ob = (lim != 0) && (sub >= lim);
    end
    f = m ? 1 : rd ? 2 : rc ? 3 : ob ? 4 : oc ? 5 : 0;
    return {a[50:47], a[46:42], 3'(kind), 4'(pe), 5'(unit), off, 3'(f)};
  endfunction

  function automatic logic [50:0] mk(int sip, int die, logic [41:0] l);
    return {4'(sip), 5'(die), l};
  endfunction
  function automatic logic [41:0] hbmL(logic [36:0] o);
    return 42'(o) | (42'd1 << 37);
  endfunction
  function automatic logic [41:0] peL(int pe, int u, logic [24:0] o);
    return (42'(pe) << 29) | (42'(u) << 25) | 42'(o);
  endfunction
  function automatic logic [41:0] mcL(int u, logic [24:0] o);
    return (42'd1 << 34) | (42'(u) << 25) | 42'(o);
  endfunction
  function automatic logic [41:0] ioL(int u, logic [26:0] o);
    return (42'(u) << 27) | 42'(o);
  endfunction

  task automatic send(logic [50:0] a, string tag);
    @(posedge clk); #2;
    inValid = 1'b1; inAddr = a;
    forever begin
      @(negedge clk);
      if (inReady) break;
    end
    expQ.push_back(model(a, capModel));
    tagQ.push_back(tag);
    @(posedge clk); #2;
    inValid = 1'b0;
  endtask

  task automatic setCap(logic [37:0] v);
    @(posedge clk); #2;
    capWrEn = 1'b1; capWrData = v;
    @(posedge clk); #2;
    capWrEn = 1'b0;
    capModel = v;
  endtask

  // R10: capacity write in the accepting cycle applies only to later addresses
  task automatic sendWithCap(logic [50:0] a, logic [37:0] v);
    @(posedge clk); #2;
    inValid = 1'b1; inAddr = a; capWrEn = 1'b1; capWrData = v;
    @(negedge clk);
    checks++;
    if (!inReady) begin
      errors++;
      $display("FAIL R12 inReady act=0 exp=1 with idle output");
    end
    expQ.push_back(model(a, capModel));
    tagQ.push_back("R10");
    @(posedge clk); #2;
    inValid = 1'b0; capWrEn = 1'b0;
    capModel = v;
  endtask

  logic [63:0] held;
  bit          stalled = 1'b0;
  always @(negedge clk) begin
    if (rstN && outValid) begin
      logic [63:0] act;
      act = {outSip, outDie, outKind, outPe, outUnit, outOffset, outFault};
      if (stalled) begin
        checks++;
        if (act !== held) begin
          errors++;
          $display("FAIL R12 stalled output changed act=%h exp=%h", act, held);
        end
      end
      if (outReady) begin
        stalled = 1'b0;
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R12 unexpected result act=%h exp=none", act);
        end else begin
          logic [63:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (act !== e) begin
            errors++;
            $display("FAIL %s addr result act=%h exp=%h", t, act, e);
          end
        end
      end else begin
        stalled = 1'b1;
        held = act;
      end
    end
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    forever begin
      @(posedge clk); #3;
      if (bpOn) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        outReady = lfsr[0] | lfsr[3];
      end else begin
        outReady = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!doneFlag) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R13 outValid in reset act=%b exp=0", outValid);
    end
    @(posedge clk); #2; rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || inReady !== 1'b1) begin
      errors++;
      $display("FAIL R13 after reset act=%b/%b exp=0/1", outValid, inReady);
    end

    send(mk(2, 5, hbmL(37'h1000)), "R1 R3");
    send(mk(15, 0, hbmL(37'h1000) | (42'd1 << 39)), "R3 mbz");
    send(mk(0, 0, peL(3, 6, 25'h400)), "R5");
    send(mk(0, 1, peL(15, 6, 25'h1F_FFFF)), "R5 R9 edge");
    send(mk(0, 1, peL(2, 6, 25'h20_0000)), "R9");
    send(mk(0, 2, peL(1, 5, 25'h2_FFFF)), "R5 R9");
    send(mk(0, 2, peL(1, 5, 25'h3_0000)), "R9");
    send(mk(0, 3, peL(4, 7, 25'h0)), "R5 reserved");
    send(mk(0, 3, peL(4, 9, 25'h0) | (42'd1 << 33)), "R11 priority");
    send(mk(0, 4, peL(0, 0, 25'h2000)), "R9 dtcm");
    send(mk(1, 3, mcL(5, 25'h0)), "R6");
    send(mk(1, 3, mcL(5, 25'h9F_FFFF)), "R6 R9 edge");
    send(mk(1, 3, mcL(5, 25'hA0_0000)), "R9");
    send(mk(1, 3, mcL(6, 25'h0)), "R6 reserved");
    send(mk(1, 3, mcL(31, 25'h0) | (42'd1 << 31)), "R6 mbz");
    send(mk(3, 7, (42'd2 << 34) | 42'h1FF_FFFF), "R7");
    send(mk(3, 7, (42'd2 << 34) | (42'd1 << 25)), "R7 mbz");
    send(mk(3, 7, (42'd3 << 34) | 42'h5), "R4");
    send(mk(3, 7, (42'd7 << 34) | 42'h5), "R4");
    send(mk(4, 21, 42'h3FF_FFFF_FFFF), "R2");
    send(mk(4, 31, 42'h12345), "R2");
    send(mk(4, 20, 42'h80_0000_0000), "R8 R1");
    send(mk(1, 17, ioL(2, 27'h2_0000)), "R8");
    send(mk(1, 16, ioL(5, 27'h3FF_FFFF)), "R8 R9 edge");
    send(mk(1, 16, ioL(15, 27'h7FF_FFFF)), "R8 reserved");
    send(mk(0, 16, 42'h0_8000_0000), "R8 ual edge");
    send(mk(0, 16, 42'h1_0000_0000), "R8 ual");
    send(mk(0, 18, 42'h100_0000_0000), "R8 mbz");
    send(mk(0, 15, hbmL(37'h1F_FFFF_FFFF)), "R10 reset cap");
    setCap(38'h18_0000_0000);
    send(mk(5, 9, hbmL(37'h17_FFFF_FFFF)), "R10 edge");
    send(mk(5, 9, hbmL(37'h18_0000_0000)), "R10");
    send(mk(5, 9, hbmL(37'h18_0000_0000) | (42'd1 << 38)), "R11 mbz over cap");
    sendWithCap(mk(5, 9, hbmL(37'h10_0000_0000)), 38'h8_0000_0000);
    send(mk(5, 9, hbmL(37'h10_0000_0000)), "R10 new cap");

    bpOn = 1'b1;
    for (int i = 0; i < 40; i++) begin
      send(mk(i % 16, i % 32, peL(i % 16, i % 8, 25'(i * 1013))), "R12 stream");
      send(mk(i % 16, 16 + (i % 5), ioL(i % 7, 27'(i * 40961))), "R12 stream");
    end
    bpOn = 1'b0;

    repeat (20) @(posedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R12 results missing act=%0d exp=0", expQ.size());
    end
    doneFlag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule